// File: doc/BRIEF.md
# Dynamic Two-Input Bitwise Lookup Unit

This execution unit evaluates a two-input Boolean function on every bit position of two 64-bit source operands, where the function is not fixed in the instruction but read at run time as a 4-entry truth table from a third source operand. A single instruction bit picks which of the two lowest nibbles of that third operand is used. Keeping two tables in one register means two consecutive operations, followed by a bitwise merge, can realise any three-input function chosen at run time.

The unit decodes a 32-bit instruction word, presents the three source register numbers to an external register file, which answers in the same cycle, and registers the result together with its destination register number. The result is held on a valid/ready write-back port until the consumer takes it. No flag or condition state is produced.

Top module: `dyn_lut2_unit`

## Requirements
- R1: The instruction word is decoded with bit 31 as the most significant bit: primary opcode in bits 31:26, destination in 25:21, first source (A) in 20:16, second source (B) in 15:11, table source (C) in 10:6, table-select in bit 5, extended opcode in 4:0; the A, B and C numbers appear on `rd_a_idx`, `rd_b_idx`, `rd_c_idx` in the same cycle.
- R2: With table-select 0 the truth table is bits 3:0 of the C operand.
- R3: With table-select 1 the truth table is bits 7:4 of the C operand; C bits outside the chosen nibble have no effect on the result.
- R4: Result bit i equals truth-table bit number {B[i],A[i]} (B the more significant index bit), so table 0x8 gives A AND B, 0xE gives A OR B and 0x6 gives A XOR B.
- R5: A request accepted with primary opcode 22 and extended opcode 3 raises `wb_valid` on the next clock edge, with `wb_idx` equal to the destination field and `wb_data` the result.
- R6: While `wb_valid` is high and `wb_ready` low, `wb_valid`, `wb_idx` and `wb_data` hold their values.
- R7: `req_ready` is high whenever `wb_valid` is low or `wb_ready` is high; an accepted word whose primary or extended opcode differs from 22/3 is consumed and produces no write-back.
- R8: While `rst_n` is low, `wb_valid` and `wb_data` clear to zero on each clock edge.
- R9: Source operands are sampled only at acceptance; a destination equal to any source, and later changes of the source values, do not alter a pending result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Instruction word is offered |
| req_ready | output | 1 | Unit can take an instruction this cycle |
| req_instr | input | 32 | Instruction word |
| rd_a_idx | output | 5 | Register number of source A |
| rd_b_idx | output | 5 | Register number of source B |
| rd_c_idx | output | 5 | Register number of table source C |
| src_a_data | input | 64 | Value of source A |
| src_b_data | input | 64 | Value of source B |
| src_c_data | input | 64 | Value of table source C |
| wb_valid | output | 1 | Result is available |
| wb_ready | input | 1 | Consumer takes the result this cycle |
| wb_idx | output | 5 | Destination register number |
| wb_data | output | 64 | Result value |

## Verification
The assertions assume the register file returns source values in the same cycle the indices are shown, and that `req_instr` and the source values are steady while `req_valid` is sampled. The bench models the register file as a combinational array indexed by the unit's own read indices and changes instruction words and register contents only on the falling clock edge, so every sampled request is consistent. Stall checks change register contents only after the request has been accepted, which is the window where the hold properties apply.

// File: rtl/dlut_pkg.sv
// Shared widths and the instruction field layout for the dynamic LUT unit.
// Assumes a 32-bit instruction with the most significant bit holding field start.
package dlut_pkg;
    localparam int INSN_W = 32;
    localparam int REG_AW = 5;
    localparam int PRIM_W = 6;
    localparam int EXT_W  = 5;
    localparam int TBL_W  = 4;

    typedef struct packed {
        logic [PRIM_W-1:0] prim;
        logic [REG_AW-1:0] dst;
        logic [REG_AW-1:0] src_a;
        logic [REG_AW-1:0] src_b;
        logic [REG_AW-1:0] src_c;
        logic              hi_sel;
        logic [EXT_W-1:0]  ext;
    } dlut_insn_t;
endpackage

// File: rtl/dlut_decode.sv
// Splits an instruction word into register numbers and the table-select bit,
// and flags whether the opcode pair names this operation. Purely combinational.
module dlut_decode
    import dlut_pkg::*;
#(
    parameter logic [PRIM_W-1:0] PRIM_OP = 6'd22,
    parameter logic [EXT_W-1:0]  EXT_OP  = 5'd3
) (
    input  logic [INSN_W-1:0] instr,
    output logic              legal,
    output logic [REG_AW-1:0] dst,
    output logic [REG_AW-1:0] src_a,
    output logic [REG_AW-1:0] src_b,
    output logic [REG_AW-1:0] src_c,
    output logic              hi_sel
);
    dlut_insn_t fields;

    // Field extraction through the packed layout.
    always_comb begin
        fields = dlut_insn_t'(instr);
        legal  = (fields.prim == PRIM_OP) && (fields.ext == EXT_OP);
        dst    = fields.dst;
        src_a  = fields.src_a;
        src_b  = fields.src_b;
        src_c  = fields.src_c;
        hi_sel = fields.hi_sel;
    end
endmodule

// File: rtl/dlut_table_sel.sv
// Picks the 4-entry truth table from the two lowest nibbles of the table operand.
// Assumes the operand is at least two nibbles wide.
module dlut_table_sel
    import dlut_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]  tbl_src,
    input  logic             hi_sel,
    output logic [TBL_W-1:0] table_bits
);
    localparam int USED_W = 2 * TBL_W;

    logic unused_upper;
    assign unused_upper = ^tbl_src[XLEN-1:USED_W];

    // Nibble choice: select 1 takes the upper of the two low nibbles.
    always_comb begin
        if (hi_sel) table_bits = tbl_src[USED_W-1:TBL_W];
        else        table_bits = tbl_src[TBL_W-1:0];
    end
endmodule

// File: rtl/dlut_bit_array.sv
// One 4:1 lookup per bit position; the B bit is the more significant index bit.
// Assumes the truth table is stable for the whole evaluation.
module dlut_bit_array
    import dlut_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    input  logic [TBL_W-1:0] table_bits,
    output logic [XLEN-1:0]  result
);
    for (genvar gi = 0; gi < XLEN; gi++) begin : g_bit
        logic [1:0] sel;
        // Per-bit index and lookup.
        always_comb begin
            sel        = {opb[gi], opa[gi]};
            result[gi] = table_bits[sel];
        end
    end
endmodule

// File: rtl/dlut_wb_reg.sv
// Result register with a valid/ready write-back handshake. A new result may be
// loaded in the same cycle the previous one is taken. Assumes load only when ready.
module dlut_wb_reg
    import dlut_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [REG_AW-1:0] load_idx,
    input  logic [XLEN-1:0]   load_data,
    input  logic              wb_ready,
    output logic              ready,
    output logic              wb_valid,
    output logic [REG_AW-1:0] wb_idx,
    output logic [XLEN-1:0]   wb_data
);
    // Space is free when empty or when the current result leaves now.
    assign ready = !wb_valid || wb_ready;

    // Capture a new result or drop the old one once it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_idx   <= '0;
            wb_data  <= '0;
        end else if (ready) begin
            wb_valid <= load;
            if (load) begin
                wb_idx  <= load_idx;
                wb_data <= load_data;
            end
        end
    end

    assert_wb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_idx) && $stable(wb_data)));

    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (!wb_valid && wb_data == '0));
endmodule

// File: rtl/dyn_lut2_unit.sv
// Top of the dynamic two-input LUT unit: decode, register reads, table choice,
// per-bit lookup and registered write-back. Assumes the register file answers
// the read indices combinationally in the same cycle.
module dyn_lut2_unit
    import dlut_pkg::*;
#(
    parameter int                XLEN    = 64,
    parameter logic [PRIM_W-1:0] PRIM_OP = 6'd22,
    parameter logic [EXT_W-1:0]  EXT_OP  = 5'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [INSN_W-1:0] req_instr,
    output logic [REG_AW-1:0] rd_a_idx,
    output logic [REG_AW-1:0] rd_b_idx,
    output logic [REG_AW-1:0] rd_c_idx,
    input  logic [XLEN-1:0]   src_a_data,
    input  logic [XLEN-1:0]   src_b_data,
    input  logic [XLEN-1:0]   src_c_data,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [REG_AW-1:0] wb_idx,
    output logic [XLEN-1:0]   wb_data
);
    logic              dec_legal;
    logic [REG_AW-1:0] dec_dst;
    logic              dec_hi;
    logic [TBL_W-1:0]  tbl;
    logic [XLEN-1:0]   lut_out;
    logic              accept;
    logic              do_load;

    dlut_decode #(.PRIM_OP(PRIM_OP), .EXT_OP(EXT_OP)) u_decode (
        .instr  (req_instr),
        .legal  (dec_legal),
        .dst    (dec_dst),
        .src_a  (rd_a_idx),
        .src_b  (rd_b_idx),
        .src_c  (rd_c_idx),
        .hi_sel (dec_hi)
    );

    dlut_table_sel #(.XLEN(XLEN)) u_table (
        .tbl_src    (src_c_data),
        .hi_sel     (dec_hi),
        .table_bits (tbl)
    );

    dlut_bit_array #(.XLEN(XLEN)) u_bits (
        .opa        (src_a_data),
        .opb        (src_b_data),
        .table_bits (tbl),
        .result     (lut_out)
    );

    // Handshake: a word is consumed whenever offered and space exists.
    assign accept  = req_valid && req_ready;
    assign do_load = accept && dec_legal;

    dlut_wb_reg #(.XLEN(XLEN)) u_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (do_load),
        .load_idx  (dec_dst),
        .load_data (lut_out),
        .wb_ready  (wb_ready),
        .ready     (req_ready),
        .wb_valid  (wb_valid),
        .wb_idx    (wb_idx),
        .wb_data   (wb_data)
    );

    assert_accept_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && dec_legal) |=> (wb_valid && wb_idx == $past(dec_dst)));

    assert_drop_foreign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !dec_legal) |=> !wb_valid);

    assert_ready_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_valid |-> req_ready);
endmodule

// File: tb/tb_dyn_lut2_unit.sv
module tb_dyn_lut2_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] OP = 6'd22;
    localparam logic [4:0] XO = 5'd3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_instr;
    logic [4:0]  rd_a_idx, rd_b_idx, rd_c_idx;
    logic [63:0] src_a_data, src_b_data, src_c_data;
    logic        wb_valid;
    logic        wb_ready;
    logic [4:0]  wb_idx;
    logic [63:0] wb_data;

    logic [63:0] regs [32];
    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign src_a_data = regs[rd_a_idx];
    assign src_b_data = regs[rd_b_idx];
    assign src_c_data = regs[rd_c_idx];

    dyn_lut2_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_instr(req_instr), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
        .rd_c_idx(rd_c_idx), .src_a_data(src_a_data), .src_b_data(src_b_data),
        .src_c_data(src_c_data), .wb_valid(wb_valid), .wb_ready(wb_ready),
        .wb_idx(wb_idx), .wb_data(wb_data)
    );

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rt,
        input logic [4:0] ra, input logic [4:0] rb, input logic [4:0] rc,
        input logic nh, input logic [4:0] xo);
        return {op, rt, ra, rb, rc, nh, xo};
    endfunction

    function automatic logic [63:0] ref_lut(input logic [63:0] a, input logic [63:0] b,
        input logic [3:0] t);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) r[i] = t[{b[i], a[i]}];
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Offer one word with wb_ready high; on return the result is visible.
    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        req_valid = 1'b1;
        req_instr = w;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] a, b, c, exp;
        for (int r = 0; r < 32; r++) regs[r] = 64'h0;
        rst_n = 1'b0; req_valid = 1'b0; wb_ready = 1'b1; req_instr = '0;
        repeat (3) @(negedge clk);
        check("R8 valid", {63'h0, wb_valid}, 64'h0);
        check("R8 data", wb_data, 64'h0);
        check("R7 ready", {63'h0, req_ready}, 64'h1);
        rst_n = 1'b1;

        // R1: field positions shown on read indices
        req_instr = mk(OP, 5'd7, 5'd3, 5'd12, 5'd25, 1'b0, XO);
        #1;
        check("R1 a idx", {59'h0, rd_a_idx}, 64'd3);
        check("R1 b idx", {59'h0, rd_b_idx}, 64'd12);
        check("R1 c idx", {59'h0, rd_c_idx}, 64'd25);

        // R2/R3/R4/R5 sweep: every table, both selects, four operand patterns
        for (int p = 0; p < 4; p++) begin
            case (p)
                0: begin a = 64'h0; b = 64'hFFFF_FFFF_FFFF_FFFF; end
                1: begin a = 64'hFFFF_FFFF_FFFF_FFFF; b = 64'h0; end
                2: begin a = 64'hF0F0_F0F0_F0F0_F0F0; b = 64'hCCCC_CCCC_CCCC_CCCC; end
                default: begin a = 64'h0123_4567_89AB_CDEF; b = 64'hFEDC_BA98_7654_3210; end
            endcase
            for (int t = 0; t < 16; t++) begin
                for (int nh = 0; nh < 2; nh++) begin
                    logic [3:0] tv;
                    tv = 4'(t);
                    // chosen nibble holds the table, the other its complement, upper bits noise
                    c = (nh == 1) ? {56'hA5C3_0F96_1E2D_3C, tv, ~tv} : {56'h5A3C_F069_E1D2_C3, ~tv, tv};
                    regs[1] = a; regs[2] = b; regs[3] = c;
                    issue(mk(OP, 5'd10, 5'd1, 5'd2, 5'd3, nh[0], XO));
                    exp = ref_lut(a, b, tv);
                    check("R5 valid", {63'h0, wb_valid}, 64'h1);
                    check("R5 idx", {59'h0, wb_idx}, 64'd10);
                    check(nh == 1 ? "R3 data" : "R2 data", wb_data, exp);
                    if (t == 8) check("R4 and", wb_data, a & b);
                    if (t == 14) check("R4 or", wb_data, a | b);
                    if (t == 6) check("R4 xor", wb_data, a ^ b);
                end
            end
        end

        // R7: foreign opcode and foreign extended opcode give no write-back
        issue(mk(OP + 6'd1, 5'd4, 5'd1, 5'd2, 5'd3, 1'b0, XO));
        check("R7 bad prim", {63'h0, wb_valid}, 64'h0);
        issue(mk(OP, 5'd4, 5'd1, 5'd2, 5'd3, 1'b0, XO + 5'd1));
        check("R7 bad ext", {63'h0, wb_valid}, 64'h0);

        // R6/R9: stall with destination equal to the table source
        a = 64'hDEAD_BEEF_0BAD_F00D; b = 64'h1234_5678_9ABC_DEF0;
        regs[1] = a; regs[2] = b; regs[3] = 64'h0000_0000_0000_0096;
        exp = ref_lut(a, b, 4'h9);
        wb_ready = 1'b0;
        issue(mk(OP, 5'd3, 5'd1, 5'd2, 5'd3, 1'b1, XO));
        check("R6 valid", {63'h0, wb_valid}, 64'h1);
        check("R7 not ready", {63'h0, req_ready}, 64'h0);
        regs[1] = ~a; regs[2] = ~b; regs[3] = 64'h0;
        repeat (3) @(negedge clk);
        check("R6 still valid", {63'h0, wb_valid}, 64'h1);
        check("R9 held data", wb_data, exp);
        check("R6 held idx", {59'h0, wb_idx}, 64'd3);
        wb_ready = 1'b1;
        @(negedge clk);
        check("R7 drained", {63'h0, wb_valid}, 64'h0);

        // R7: back-to-back acceptance while the previous result leaves
        regs[1] = a; regs[2] = b; regs[3] = 64'h0000_0000_0000_00E8;
        @(negedge clk);
        req_valid = 1'b1;
        req_instr = mk(OP, 5'd20, 5'd1, 5'd2, 5'd3, 1'b0, XO);
        @(negedge clk);
        check("R7 first", wb_data, a & b);
        req_instr = mk(OP, 5'd21, 5'd1, 5'd2, 5'd3, 1'b1, XO);
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 second", wb_data, a | b);
        check("R7 second idx", {59'h0, wb_idx}, 64'd21);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule